// File: doc/BRIEF.md
# Masked 128-Bit Lane Shuffle Unit

This block is a vector permute datapath. It assembles a 256-bit or 512-bit result out of 128-bit lanes taken from two source vectors. An 8-bit selector immediate chooses the lanes. The lower half of the result only ever draws from the first source, and the upper half only from the second. The second source can first be expanded from a single 32-bit or 64-bit element when it was fetched from memory with broadcast requested.

A per-element write mask is applied after the shuffle. Each element is 32 or 64 bits wide, selected per operation. An element whose mask bit is set, or any element when masking is off, takes the shuffled value. Any other element either keeps the previous destination value (merge) or is cleared (zeroing). Every bit above the active vector length is driven to zero. A 128-bit length request is illegal: the unit flags it and passes the old destination through unchanged.

The unit accepts one operation per cycle, qualified by a valid strobe. The result and its flags are registered and appear one cycle later with an output valid. Integer and floating-point forms share the datapath, since no arithmetic is performed.

Top module: `lane_shuf_unit`

## Requirements
- R1: In 512-bit mode (`vlen_sel`=2'b10), result lane 0 (bits 127:0) is first-source lane `sel_imm[1:0]`, and result lane 1 is first-source lane `sel_imm[3:2]`. Source lane n occupies bits 128n+127:128n.
- R2: In 512-bit mode, result lane 2 is second-source lane `sel_imm[5:4]`, and result lane 3 is second-source lane `sel_imm[7:6]`.
- R3: In 256-bit mode (`vlen_sel`=2'b01), result lane 0 is first-source lane `sel_imm[0]` and result lane 1 is second-source lane `sel_imm[1]`. `sel_imm[7:2]` has no effect.
- R4: When `bcast` and `b_is_mem` are both 1, every element of the second source is replaced by its element 0 before lane selection. Element 0 is bits 31:0 when `elem64`=0 and bits 63:0 when `elem64`=1. `bcast` with `b_is_mem`=0 has no effect.
- R5: The mask has one bit per element. With `elem64`=0, bit j governs bits 32j+31:32j. With `elem64`=1, bit j governs bits 64j+63:64j.
- R6: With `mask_on`=1 and `zero_mode`=0, an element whose mask bit is 0 takes the `old_dst` value at the same position.
- R7: With `mask_on`=1 and `zero_mode`=1, an element whose mask bit is 0 is zero.
- R8: With `mask_on`=0, every active element takes the shuffled value, whatever `mask_bits` holds.
- R9: In 256-bit mode, `dst_out[511:256]` is zero.
- R10: A `vlen_sel` of 2'b00 or 2'b11 is illegal. The result then has `bad_len`=1 and `dst_out` equal to `old_dst`. Legal lengths give `bad_len`=0.
- R11: Each operation's result appears with `out_valid`=1 exactly one cycle after `in_valid`=1. With `in_valid`=0, `out_valid` is 0 the next cycle and `dst_out` and `bad_len` hold.
- R12: Mask bits at or above the element count of the active length have no effect. The counts are 16 or 8 at 512 bits and 8 or 4 at 256 bits.
- R13: While `rst_n` is 0 at a clock edge, `out_valid`, `bad_len` and `dst_out` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 512 | First source vector (feeds low result lanes) |
| src_b | input | 512 | Second source vector (feeds high result lanes) |
| old_dst | input | 512 | Previous destination value for merging |
| sel_imm | input | 8 | Lane selector immediate |
| vlen_sel | input | 2 | Length: 01 = 256, 10 = 512, others illegal |
| elem64 | input | 1 | Element size: 0 = 32-bit, 1 = 64-bit |
| mask_bits | input | 16 | Per-element write mask |
| mask_on | input | 1 | Enables the write mask |
| zero_mode | input | 1 | 1 = clear unselected elements, 0 = merge |
| bcast | input | 1 | Broadcast request for the second source |
| b_is_mem | input | 1 | Second source was fetched from memory |
| out_valid | output | 1 | Result valid |
| dst_out | output | 512 | New destination value |
| bad_len | output | 1 | Illegal length flag for the result |

## Verification
A wrong lane index or a swapped source shows up as a whole 128-bit lane carrying another lane's data. Such an error reaches the port on the cycle after the operation. A mask decoded at the wrong granularity corrupts single 32-bit words, and only in the 64-bit element mode. A stale upper-length region shows as non-zero bits above 256 in the shorter mode. A validity register that drops or repeats a strobe appears as a missing or unexpected result on the next cycle.

// File: rtl/lshuf_pkg.sv
// Package: shared widths and the vector-length encoding of the lane shuffle
// unit. Assumes a 512-bit maximum vector built from 128-bit lanes.
package lshuf_pkg;
    localparam int VEC_W  = 512;
    localparam int LANE_W = 128;
    localparam int WORD_W = 32;
    localparam int LANES  = VEC_W / LANE_W;
    localparam int WORDS  = VEC_W / WORD_W;
    localparam int SEL_W  = $clog2(LANES);
    localparam int IMM_W  = LANES * SEL_W;

    typedef enum logic [1:0] {
        VL_128  = 2'b00,
        VL_256  = 2'b01,
        VL_512  = 2'b10,
        VL_RSVD = 2'b11
    } vlen_e;
endpackage

// File: rtl/lshuf_bcast.sv
// Module: lshuf_bcast
// Replicates element 0 of the source into every element position when the
// broadcast enable is set; otherwise the source passes through unchanged.
// Assumes 64-bit elements are built from two adjacent 32-bit words.
module lshuf_bcast #(
    parameter int VEC_W  = 512,
    parameter int WORD_W = 32
) (
    input  logic [VEC_W-1:0] src,
    input  logic             bcast_en,
    input  logic             elem64,
    output logic [VEC_W-1:0] dst
);
    localparam int WORDS = VEC_W / WORD_W;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Choose, per 32-bit word, between pass-through and element-0 copy.
        always_comb begin
            if (!bcast_en)
                dst[w*WORD_W +: WORD_W] = src[w*WORD_W +: WORD_W];
            else if (elem64)
                dst[w*WORD_W +: WORD_W] = src[(w % 2)*WORD_W +: WORD_W];
            else
                dst[w*WORD_W +: WORD_W] = src[WORD_W-1:0];
        end
    end
endmodule

// File: rtl/lshuf_lane_sel.sv
// Module: lshuf_lane_sel
// Builds the shuffled vector at 128-bit lane granularity. In full-length mode
// the lower half of the result lanes indexes the low source and the upper
// half indexes the high source, each with an SEL_W-bit immediate field. In
// half-length mode the lower quarter comes from the low source and the next
// quarter from the high source, each with an (SEL_W-1)-bit field; lanes above
// the half are zero. Assumes LANES is a power of two and at least 4.
module lshuf_lane_sel #(
    parameter int VEC_W  = 512,
    parameter int LANE_W = 128
) (
    input  logic [VEC_W-1:0]                             src_lo,
    input  logic [VEC_W-1:0]                             src_hi,
    input  logic [(VEC_W/LANE_W)*$clog2(VEC_W/LANE_W)-1:0] imm,
    input  logic                                         full,
    output logic [VEC_W-1:0]                             shuf
);
    localparam int LANES  = VEC_W / LANE_W;
    localparam int SEL_W  = $clog2(LANES);
    localparam int HSEL_W = SEL_W - 1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SEL_W-1:0]  idx_full;
        logic [LANE_W-1:0] pick_full;
        logic [LANE_W-1:0] pick_half;

        // Full-length pick: lower half from the low source, upper half from the high source.
        always_comb begin
            idx_full = imm[i*SEL_W +: SEL_W];
            if (i < LANES/2)
                pick_full = src_lo[idx_full*LANE_W +: LANE_W];
            else
                pick_full = src_hi[idx_full*LANE_W +: LANE_W];
        end

        if (i < LANES/2) begin : g_half_live
            logic [SEL_W-1:0] idx_half;
            // Half-length pick: narrower field, lanes restricted to the lower half of each source.
            always_comb begin
                idx_half = SEL_W'(imm[i*HSEL_W +: HSEL_W]);
                if (i < LANES/4)
                    pick_half = src_lo[idx_half*LANE_W +: LANE_W];
                else
                    pick_half = src_hi[idx_half*LANE_W +: LANE_W];
            end
        end else begin : g_half_dead
            assign pick_half = '0;
        end

        // Select between the full-length and half-length pick for this lane.
        assign shuf[i*LANE_W +: LANE_W] = full ? pick_full : pick_half;
    end
endmodule

// File: rtl/lshuf_mask.sv
// Module: lshuf_mask
// Applies the per-element write mask to the shuffled vector, with merge or
// zeroing of unselected elements, and zeros all words above the active
// length. Assumes the half-length mode covers the lower half of the vector
// and that a 64-bit element is two adjacent 32-bit words sharing one mask bit.
module lshuf_mask #(
    parameter int VEC_W  = 512,
    parameter int WORD_W = 32
) (
    input  logic [VEC_W-1:0]        shuf,
    input  logic [VEC_W-1:0]        old,
    input  logic [VEC_W/WORD_W-1:0] mask,
    input  logic                    mask_on,
    input  logic                    zero_mode,
    input  logic                    elem64,
    input  logic                    full,
    output logic [VEC_W-1:0]        res
);
    localparam int WORDS = VEC_W / WORD_W;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic active;
        logic mbit;
        logic keep;

        // Decide whether this word is live and whether its element is selected.
        always_comb begin
            active = full || (w < WORDS/2);
            mbit   = elem64 ? mask[w/2] : mask[w];
            keep   = !mask_on || mbit;
        end

        // Produce the word: shuffled, merged, zeroed, or cleared above length.
        always_comb begin
            if (!active)
                res[w*WORD_W +: WORD_W] = '0;
            else if (keep)
                res[w*WORD_W +: WORD_W] = shuf[w*WORD_W +: WORD_W];
            else if (zero_mode)
                res[w*WORD_W +: WORD_W] = '0;
            else
                res[w*WORD_W +: WORD_W] = old[w*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/lane_shuf_unit.sv
// Module: lane_shuf_unit
// Top of the masked 128-bit lane shuffle unit. Decodes the length, optionally
// broadcasts the second source, shuffles lanes, applies the write mask and
// registers the result one cycle behind the input strobe. Illegal lengths
// return the old destination with an error flag. Assumes a synchronous
// active-low reset and one operation per cycle at most.
module lane_shuf_unit
    import lshuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [511:0]     src_a,
    input  logic [511:0]     src_b,
    input  logic [511:0]     old_dst,
    input  logic [7:0]       sel_imm,
    input  logic [1:0]       vlen_sel,
    input  logic             elem64,
    input  logic [15:0]      mask_bits,
    input  logic             mask_on,
    input  logic             zero_mode,
    input  logic             bcast,
    input  logic             b_is_mem,
    output logic             out_valid,
    output logic [511:0]     dst_out,
    output logic             bad_len
);
    vlen_e              vlen;
    logic               len_ok;
    logic               full;
    logic               bcast_en;
    logic [VEC_W-1:0]   b_eff;
    logic [VEC_W-1:0]   shuf;
    logic [VEC_W-1:0]   masked;

    // Decode the length field into legality and the full-length select.
    always_comb begin
        vlen     = vlen_e'(vlen_sel);
        len_ok   = (vlen == VL_256) || (vlen == VL_512);
        full     = (vlen == VL_512);
        bcast_en = bcast && b_is_mem;
    end

    lshuf_bcast #(.VEC_W(VEC_W), .WORD_W(WORD_W)) bcast_i (
        .src      (src_b),
        .bcast_en (bcast_en),
        .elem64   (elem64),
        .dst      (b_eff)
    );

    lshuf_lane_sel #(.VEC_W(VEC_W), .LANE_W(LANE_W)) lane_sel_i (
        .src_lo (src_a),
        .src_hi (b_eff),
        .imm    (sel_imm),
        .full   (full),
        .shuf   (shuf)
    );

    lshuf_mask #(.VEC_W(VEC_W), .WORD_W(WORD_W)) mask_i (
        .shuf      (shuf),
        .old       (old_dst),
        .mask      (mask_bits),
        .mask_on   (mask_on),
        .zero_mode (zero_mode),
        .elem64    (elem64),
        .full      (full),
        .res       (masked)
    );

    // Register the result and flags one cycle behind the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            bad_len   <= 1'b0;
            dst_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                bad_len <= !len_ok;
                dst_out <= len_ok ? masked : old_dst;
            end
        end
    end
endmodule

// File: rtl/lane_shuf_unit_chk.sv
// Module: lane_shuf_unit_chk
// Port-level checker for lane_shuf_unit, attached by bind. Assumes the same
// length encoding as the unit: 01 = 256 bits, 10 = 512 bits.
module lane_shuf_unit_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [511:0] old_dst,
    input logic [1:0]   vlen_sel,
    input logic [15:0]  mask_bits,
    input logic         mask_on,
    input logic         zero_mode,
    input logic         out_valid,
    input logic [511:0] dst_out,
    input logic         bad_len
);
    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dst_out) && $stable(bad_len)));

    assert_illegal_passes_old_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (vlen_sel == 2'b00 || vlen_sel == 2'b11))
        |=> (bad_len && dst_out == $past(old_dst)));

    assert_legal_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (vlen_sel == 2'b01 || vlen_sel == 2'b10)) |=> !bad_len);

    assert_upper_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'b01) |=> (dst_out[511:256] == '0));

    assert_zero_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'b10 && mask_on && zero_mode && mask_bits == '0)
        |=> (dst_out == '0));

    assert_merge_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'b10 && mask_on && !zero_mode && mask_bits == '0)
        |=> (dst_out == $past(old_dst)));
endmodule

bind lane_shuf_unit lane_shuf_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .old_dst   (old_dst),
    .vlen_sel  (vlen_sel),
    .mask_bits (mask_bits),
    .mask_on   (mask_on),
    .zero_mode (zero_mode),
    .out_valid (out_valid),
    .dst_out   (dst_out),
    .bad_len   (bad_len)
);

// File: tb/lane_shuf_unit_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for lane_shuf_unit: the driver pushes expected results,
// and a monitor pops and compares them when out_valid appears.
module lane_shuf_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src_a = '0;
    logic [511:0] src_b = '0;
    logic [511:0] old_dst = '0;
    logic [7:0]   sel_imm = '0;
    logic [1:0]   vlen_sel = 2'b10;
    logic         elem64 = 1'b0;
    logic [15:0]  mask_bits = '0;
    logic         mask_on = 1'b0;
    logic         zero_mode = 1'b0;
    logic         bcast = 1'b0;
    logic         b_is_mem = 1'b0;
    logic         out_valid;
    logic [511:0] dst_out;
    logic         bad_len;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [511:0] q_dst[$];
    logic         q_bad[$];
    string        q_tag[$];

    always #4 clk = ~clk;

    lane_shuf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
        .sel_imm(sel_imm), .vlen_sel(vlen_sel), .elem64(elem64),
        .mask_bits(mask_bits), .mask_on(mask_on), .zero_mode(zero_mode),
        .bcast(bcast), .b_is_mem(b_is_mem),
        .out_valid(out_valid), .dst_out(dst_out), .bad_len(bad_len)
    );

    // Reference result computed from the requirements.
    function automatic logic [512:0] model(
        input logic [511:0] a, input logic [511:0] b, input logic [511:0] old,
        input logic [7:0] imm, input logic [1:0] vl, input logic e64,
        input logic [15:0] m, input logic mon, input logic zm,
        input logic bc, input logic mem);
        logic [511:0] bb;
        logic [511:0] t;
        logic [511:0] r;
        int nwords;
        if (vl != 2'b01 && vl != 2'b10) return {1'b1, old};
        bb = b;
        if (bc && mem)
            for (int w = 0; w < 16; w++)
                bb[w*32 +: 32] = e64 ? b[(w % 2)*32 +: 32] : b[31:0];
        t = '0;
        if (vl == 2'b10) begin
            t[127:0]   = a[imm[1:0]*128 +: 128];
            t[255:128] = a[imm[3:2]*128 +: 128];
            t[383:256] = bb[imm[5:4]*128 +: 128];
            t[511:384] = bb[imm[7:6]*128 +: 128];
            nwords = 16;
        end else begin
            t[127:0]   = a[imm[0]*128 +: 128];
            t[255:128] = bb[imm[1]*128 +: 128];
            nwords = 8;
        end
        r = '0;
        for (int w = 0; w < nwords; w++) begin
            int e;
            e = e64 ? w / 2 : w;
            if (!mon || m[e]) r[w*32 +: 32] = t[w*32 +: 32];
            else if (!zm)     r[w*32 +: 32] = old[w*32 +: 32];
        end
        return {1'b0, r};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [512:0] act, input logic [512:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present one operation and push its expected result.
    task automatic send(input logic [511:0] a, input logic [511:0] b, input logic [511:0] old,
                        input logic [7:0] imm, input logic [1:0] vl, input logic e64,
                        input logic [15:0] m, input logic mon, input logic zm,
                        input logic bc, input logic mem, input string tag);
        logic [512:0] x;
        @(negedge clk);
        src_a = a; src_b = b; old_dst = old; sel_imm = imm; vlen_sel = vl;
        elem64 = e64; mask_bits = m; mask_on = mon; zero_mode = zm;
        bcast = bc; b_is_mem = mem; in_valid = 1'b1;
        x = model(a, b, old, imm, vl, e64, m, mon, zm, bc, mem);
        q_dst.push_back(x[511:0]);
        q_bad.push_back(x[512]);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: compare each produced result with the oldest expected one.
    always @(negedge clk) begin
        if (rst_n && !finished && out_valid) begin
            if (q_dst.size() == 0) begin
                check(1'b0, "R11 unexpected out_valid", {bad_len, dst_out}, '0);
            end else begin
                logic [512:0] e;
                string t;
                e = {q_bad.pop_front(), q_dst.pop_front()};
                t = q_tag.pop_front();
                check({bad_len, dst_out} == e, t, {bad_len, dst_out}, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [511:0] pa, pb, po, held;
        for (int w = 0; w < 16; w++) begin
            pa[w*32 +: 32] = 32'hA000_0000 + w;
            pb[w*32 +: 32] = 32'hB000_0000 + w;
            po[w*32 +: 32] = 32'hC000_0000 + w;
        end
        // R13: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 0 && bad_len == 0 && dst_out == '0, "R13 reset state",
              {bad_len, dst_out}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        send(pa, pb, po, 8'h1B, 2'b10, 0, 16'h0000, 0, 0, 0, 0, "R1 R2 R8 512 reversed lanes");
        send(pa, pb, po, 8'hE4, 2'b10, 0, 16'h1234, 0, 1, 0, 0, "R1 R2 R8 512 identity mask off");
        send(pa, pb, po, 8'h50, 2'b10, 1, 16'h0000, 0, 0, 0, 0, "R1 R2 512 repeated lanes");
        send(pa, pb, po, 8'hFE, 2'b01, 0, 16'h0000, 0, 0, 0, 0, "R3 R9 256 upper imm ignored");
        send(pa, pb, po, 8'h01, 2'b01, 1, 16'h0000, 0, 0, 0, 0, "R3 R9 256 lane pick");
        send(pa, pb, po, 8'hE4, 2'b10, 0, 16'h0000, 0, 0, 1, 1, "R4 broadcast 32-bit");
        send(pa, pb, po, 8'hB1, 2'b10, 1, 16'h0000, 0, 0, 1, 1, "R4 broadcast 64-bit");
        send(pa, pb, po, 8'hE4, 2'b10, 0, 16'h0000, 0, 0, 1, 0, "R4 broadcast without memory ignored");
        send(pa, pb, po, 8'h1B, 2'b10, 0, 16'hA5C3, 1, 0, 0, 0, "R5 R6 merge 32-bit");
        send(pa, pb, po, 8'h1B, 2'b10, 1, 16'h0096, 1, 0, 0, 0, "R5 R6 merge 64-bit");
        send(pa, pb, po, 8'h4E, 2'b10, 0, 16'h3C0F, 1, 1, 0, 0, "R5 R7 zero 32-bit");
        send(pa, pb, po, 8'h4E, 2'b10, 1, 16'h0069, 1, 1, 0, 0, "R5 R7 zero 64-bit");
        send(pa, pb, po, 8'h03, 2'b01, 0, 16'hFF00, 1, 0, 0, 0, "R12 256 32-bit upper mask ignored");
        send(pa, pb, po, 8'h02, 2'b01, 1, 16'hFFF5, 1, 1, 0, 0, "R12 256 64-bit upper mask ignored");
        send(pa, pb, po, 8'h1B, 2'b10, 1, 16'hFF00, 1, 1, 0, 0, "R12 512 64-bit upper mask ignored");
        send(pa, pb, po, 8'h1B, 2'b00, 0, 16'hFFFF, 0, 0, 0, 0, "R10 illegal length 128");
        send(pa, pb, po, 8'h1B, 2'b11, 0, 16'hFFFF, 1, 1, 0, 0, "R10 illegal reserved length");
        send(pa, pb, po, 8'h1B, 2'b10, 0, 16'h0000, 1, 1, 0, 0, "R7 R10 legal after illegal");

        // Randomised back-to-back traffic across all modes.
        for (int n = 0; n < 60; n++) begin
            logic [511:0] ra, rb, ro;
            for (int w = 0; w < 16; w++) begin
                ra[w*32 +: 32] = $urandom;
                rb[w*32 +: 32] = $urandom;
                ro[w*32 +: 32] = $urandom;
            end
            send(ra, rb, ro, 8'($urandom), 2'($urandom), 1'($urandom), 16'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R1 R3 R5 R10 random mix");
        end

        // R11: idle cycles hold the output and drop out_valid.
        idle(2);
        held = dst_out;
        idle(3);
        check(out_valid == 0 && dst_out == held, "R11 idle hold",
              {out_valid, dst_out}, {1'b0, held});
        check(q_dst.size() == 0, "R11 all results delivered",
              513'(q_dst.size()), '0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule